// File: doc/BRIEF.md
# MII Management Target (PHY Side)

This block is the responding end of the two-wire MII management bus. A station manager clocks serial frames on MDC and MDIO. The block samples both lines with its own system clock and treats each rising edge of MDC as one bit. It waits for a run of at least 32 ones on MDIO. It then decodes the start pattern, the access type, a 5-bit station address and a 5-bit register number. When the station address matches the address strapped on its pins, it serves the access from a bank of 32 registers, each 16 bits wide.

For a read, the block takes the shared MDIO line during the second turnaround bit. It returns the selected register most significant bit first and then lets the line go. For a write, it gathers the 16 data bits and stores them once the final bit has arrived. Frames for other stations, frames with a bad start pattern and frames with an access code it does not support leave the registers alone and never turn on the output driver. After every frame, the block needs a new full run of ones before it accepts another. Local logic on the chip writes and reads the same registers through a simple parallel port.

Top module: `phy_mgmt_target`

## Requirements
- R1: While reset is asserted and after it is released, mdio_oe_o is 0 and every register reads 0x0000 on the local read port.
- R2: A frame is decoded only if at least 32 consecutive ones were sampled on MDIO before its start pattern. With 31 ones the frame has no effect, and runs longer than 32 are accepted.
- R3: The start pattern is a 0 followed by a 1. Any other pair makes the block drop the frame, with no register change and no drive.
- R4: Access code 2'b10 (first bit sent first) is a read and 2'b01 is a write. Codes 2'b00 and 2'b11 are ignored: there is no drive and no register change.
- R5: The 5-bit station address field (sent MSB first, after the access code) must equal phy_addr_i. Otherwise mdio_oe_o stays 0 for the whole frame and a write does not alter any register.
- R6: On a matching read, the first turnaround bit is left undriven and the second is driven 0. The 16 bits of the register named by the 5-bit register field (MSB first) follow. mdio_oe_o returns to 0 after the last data bit has been sampled.
- R7: On a matching write, the 16 data bits that follow the two turnaround bits (MSB first) are stored into the addressed register only after the last data bit, and they then appear on loc_rdata_o.
- R8: When any frame ends, including a dropped or ignored one, the count of ones is cleared. A frame that follows at once with no new preamble is ignored.
- R9: MDIO is sampled on MDC rising edges. mdio_o and mdio_oe_o change only within SYNC_STAGES+1 clk cycles after an MDC rising edge (60 ns at 50 MHz with the default of 2).
- R10: A local write (loc_we_i) sets the chosen register on the next clk edge, and later bus reads return that value. loc_rdata_o shows the register selected by loc_raddr_i without a clock delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than MDC |
| rst_n | input | 1 | Active-low asynchronous reset |
| mdc_i | input | 1 | Management clock from the station manager |
| mdio_i | input | 1 | Level of the shared MDIO line |
| mdio_o | output | 1 | Value driven onto MDIO while enabled |
| mdio_oe_o | output | 1 | Output enable for the MDIO driver |
| phy_addr_i | input | 5 | Strapped station address of this target |
| loc_we_i | input | 1 | Local register write strobe |
| loc_waddr_i | input | 5 | Local write register number |
| loc_wdata_i | input | 16 | Local write data |
| loc_raddr_i | input | 5 | Local read register number |
| loc_rdata_o | output | 16 | Contents of the register at loc_raddr_i |

## Verification
The assertions assume that MDC is slow compared with clk, so that every MDC rising edge is seen as exactly one sampled bit. They also assume that MDIO holds steady around each rising edge, and that the manager never drives the line while the target has it. The stimulus keeps within these limits. It builds each MDC phase from eight clk cycles and changes MDIO only while MDC is low. It releases the line for the full turnaround and data phase of every read, and a pull-up model supplies a 1 whenever no one drives. The bench samples each bit late in the low phase, the way a real manager does.

// File: rtl/pmt_pkg.sv
package pmt_pkg;
    localparam int PHY_AW   = 5;
    localparam int REG_AW   = 5;
    localparam int DATA_W   = 16;
    localparam int PRE_ONES = 32;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;

    typedef enum logic [2:0] {
        ST_HUNT,
        ST_START,
        ST_HDR,
        ST_TURN,
        ST_DATA
    } frame_state_e;
endpackage

// File: rtl/pmt_in_sync.sv
module pmt_in_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic mdc_i,
    input  logic mdio_i,
    output logic bit_vld_o,
    output logic bit_o
);
    typedef struct packed {
        logic [STAGES-1:0] mdc;
        logic [STAGES-1:0] dio;
        logic              mdc_prev;
    } sync_t;

    sync_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.mdc      = (s_q.mdc << 1) | STAGES'(mdc_i);
        s_d.dio      = (s_q.dio << 1) | STAGES'(mdio_i);
        s_d.mdc_prev = s_q.mdc[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.mdc      <= '0;
            s_q.dio      <= '1;
            s_q.mdc_prev <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // both chains have equal depth, so the data bit lines up with the edge
    assign bit_vld_o = s_q.mdc[STAGES-1] & ~s_q.mdc_prev;
    assign bit_o     = s_q.dio[STAGES-1];
endmodule

// File: rtl/pmt_reg_bank.sv
module pmt_reg_bank #(
    parameter int AW     = 5,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              loc_we_i,
    input  logic [AW-1:0]     loc_waddr_i,
    input  logic [DATA_W-1:0] loc_wdata_i,
    input  logic [AW-1:0]     loc_raddr_i,
    output logic [DATA_W-1:0] loc_rdata_o,
    input  logic              bus_we_i,
    input  logic [AW-1:0]     bus_waddr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    input  logic [AW-1:0]     bus_raddr_i,
    output logic [DATA_W-1:0] bus_rdata_o
);
    localparam int NREG = 2 ** AW;

    logic [DATA_W-1:0] regs_d [NREG];
    logic [DATA_W-1:0] regs_q [NREG];

    for (genvar i = 0; i < NREG; i++) begin : g_reg
        always_comb begin
            regs_d[i] = regs_q[i];
            if (loc_we_i && (loc_waddr_i == AW'(i))) begin
                regs_d[i] = loc_wdata_i;
            end
            // a bus commit wins over a local write to the same register
            if (bus_we_i && (bus_waddr_i == AW'(i))) begin
                regs_d[i] = bus_wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                regs_q[i] <= '0;
            end else begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign loc_rdata_o = regs_q[loc_raddr_i];
    assign bus_rdata_o = regs_q[bus_raddr_i];
endmodule

// File: rtl/pmt_frame_fsm.sv
module pmt_frame_fsm
    import pmt_pkg::*;
#(
    parameter int PHY_AW   = pmt_pkg::PHY_AW,
    parameter int REG_AW   = pmt_pkg::REG_AW,
    parameter int DATA_W   = pmt_pkg::DATA_W,
    parameter int PRE_ONES = pmt_pkg::PRE_ONES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bit_vld_i,
    input  logic              bit_i,
    input  logic [PHY_AW-1:0] phy_addr_i,
    output logic [REG_AW-1:0] rd_addr_o,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    output logic              we_o,
    output logic [REG_AW-1:0] waddr_o,
    output logic [DATA_W-1:0] wdata_o
);
    localparam int HDR_W = 2 + PHY_AW + REG_AW;
    localparam int PCW   = $clog2(PRE_ONES + 1);
    localparam int CW    = $clog2(HDR_W + DATA_W);

    typedef struct packed {
        frame_state_e      st;
        logic [PCW-1:0]    ones;
        logic [CW-1:0]     cnt;
        logic [HDR_W-1:0]  hdr;
        logic              is_rd;
        logic              hit;
        logic [DATA_W-1:0] sh;
        logic              oe;
        logic              dout;
        logic              we;
        logic [REG_AW-1:0] waddr;
        logic [DATA_W-1:0] wdata;
    } fsm_t;

    fsm_t f_d, f_q;

    logic [HDR_W-1:0]  hdr_n;
    logic [DATA_W-1:0] sh_n;
    logic [1:0]        op_n;
    logic [PHY_AW-1:0] phy_n;
    logic              serve;

    assign hdr_n     = {f_q.hdr[HDR_W-2:0], bit_i};
    assign sh_n      = {f_q.sh[DATA_W-2:0], bit_i};
    assign op_n      = hdr_n[HDR_W-1 -: 2];
    assign phy_n     = hdr_n[REG_AW +: PHY_AW];
    assign rd_addr_o = hdr_n[REG_AW-1:0];
    assign serve     = f_q.is_rd & f_q.hit;

    always_comb begin
        f_d    = f_q;
        f_d.we = 1'b0;
        if (bit_vld_i) begin
            unique case (f_q.st)
                ST_HUNT: begin
                    if (bit_i) begin
                        if (f_q.ones < PCW'(PRE_ONES)) begin
                            f_d.ones = f_q.ones + 1'b1;
                        end
                    end else begin
                        if (f_q.ones == PCW'(PRE_ONES)) begin
                            f_d.st = ST_START;
                        end
                        f_d.ones = '0;
                    end
                end
                ST_START: begin
                    f_d.cnt = '0;
                    f_d.st  = bit_i ? ST_HDR : ST_HUNT;
                end
                ST_HDR: begin
                    f_d.hdr = hdr_n;
                    if (f_q.cnt == CW'(HDR_W - 1)) begin
                        f_d.cnt = '0;
                        if ((op_n == OP_READ) || (op_n == OP_WRITE)) begin
                            f_d.st    = ST_TURN;
                            f_d.is_rd = (op_n == OP_READ);
                            f_d.hit   = (phy_n == phy_addr_i);
                            f_d.sh    = rd_data_i;
                        end else begin
                            f_d.st = ST_HUNT;
                        end
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                    end
                end
                ST_TURN: begin
                    if (f_q.cnt == '0) begin
                        f_d.cnt = CW'(1);
                        if (serve) begin
                            f_d.oe   = 1'b1;
                            f_d.dout = 1'b0;
                        end
                    end else begin
                        f_d.cnt = '0;
                        f_d.st  = ST_DATA;
                        f_d.sh  = sh_n;
                        if (serve) begin
                            f_d.dout = f_q.sh[DATA_W-1];
                        end
                    end
                end
                ST_DATA: begin
                    f_d.sh = sh_n;
                    if (f_q.cnt == CW'(DATA_W - 1)) begin
                        f_d.st   = ST_HUNT;
                        f_d.ones = '0;
                        f_d.cnt  = '0;
                        f_d.oe   = 1'b0;
                        f_d.dout = 1'b0;
                        if (!f_q.is_rd && f_q.hit) begin
                            f_d.we    = 1'b1;
                            f_d.waddr = f_q.hdr[REG_AW-1:0];
                            f_d.wdata = sh_n;
                        end
                    end else begin
                        f_d.cnt = f_q.cnt + 1'b1;
                        if (serve) begin
                            f_d.dout = f_q.sh[DATA_W-1];
                        end
                    end
                end
                default: begin
                    f_d.st   = ST_HUNT;
                    f_d.ones = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            f_q.st    <= ST_HUNT;
            f_q.ones  <= '0;
            f_q.cnt   <= '0;
            f_q.hdr   <= '0;
            f_q.is_rd <= 1'b0;
            f_q.hit   <= 1'b0;
            f_q.sh    <= '0;
            f_q.oe    <= 1'b0;
            f_q.dout  <= 1'b0;
            f_q.we    <= 1'b0;
            f_q.waddr <= '0;
            f_q.wdata <= '0;
        end else begin
            f_q <= f_d;
        end
    end

    assign mdio_o    = f_q.dout;
    assign mdio_oe_o = f_q.oe;
    assign we_o      = f_q.we;
    assign waddr_o   = f_q.waddr;
    assign wdata_o   = f_q.wdata;
endmodule

// File: rtl/phy_mgmt_target.sv
module phy_mgmt_target #(
    parameter int PHY_AW      = pmt_pkg::PHY_AW,
    parameter int REG_AW      = pmt_pkg::REG_AW,
    parameter int DATA_W      = pmt_pkg::DATA_W,
    parameter int PRE_ONES    = pmt_pkg::PRE_ONES,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdc_i,
    input  logic              mdio_i,
    output logic              mdio_o,
    output logic              mdio_oe_o,
    input  logic [PHY_AW-1:0] phy_addr_i,
    input  logic              loc_we_i,
    input  logic [REG_AW-1:0] loc_waddr_i,
    input  logic [DATA_W-1:0] loc_wdata_i,
    input  logic [REG_AW-1:0] loc_raddr_i,
    output logic [DATA_W-1:0] loc_rdata_o
);
    logic              mdc_rise;
    logic              mdio_bit;
    logic              bus_we;
    logic [REG_AW-1:0] bus_waddr;
    logic [DATA_W-1:0] bus_wdata;
    logic [REG_AW-1:0] bus_raddr;
    logic [DATA_W-1:0] bus_rdata;

    pmt_in_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .mdc_i     (mdc_i),
        .mdio_i    (mdio_i),
        .bit_vld_o (mdc_rise),
        .bit_o     (mdio_bit)
    );

    pmt_frame_fsm #(
        .PHY_AW   (PHY_AW),
        .REG_AW   (REG_AW),
        .DATA_W   (DATA_W),
        .PRE_ONES (PRE_ONES)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_vld_i  (mdc_rise),
        .bit_i      (mdio_bit),
        .phy_addr_i (phy_addr_i),
        .rd_addr_o  (bus_raddr),
        .rd_data_i  (bus_rdata),
        .mdio_o     (mdio_o),
        .mdio_oe_o  (mdio_oe_o),
        .we_o       (bus_we),
        .waddr_o    (bus_waddr),
        .wdata_o    (bus_wdata)
    );

    pmt_reg_bank #(.AW(REG_AW), .DATA_W(DATA_W)) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .loc_we_i    (loc_we_i),
        .loc_waddr_i (loc_waddr_i),
        .loc_wdata_i (loc_wdata_i),
        .loc_raddr_i (loc_raddr_i),
        .loc_rdata_o (loc_rdata_o),
        .bus_we_i    (bus_we),
        .bus_waddr_i (bus_waddr),
        .bus_wdata_i (bus_wdata),
        .bus_raddr_i (bus_raddr),
        .bus_rdata_o (bus_rdata)
    );
endmodule

// File: rtl/phy_mgmt_target_chk.sv
module phy_mgmt_target_chk (
    input logic clk,
    input logic rst_n,
    input logic mdc_rise,
    input logic mdio_o,
    input logic mdio_oe,
    input logic bus_we
);
    // the driver enable moves only in the cycle after a sampled MDC edge
    assert_oe_after_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe != $past(mdio_oe)) |-> $past(mdc_rise));

    // a driven data bit changes only in the cycle after a sampled MDC edge
    assert_dout_after_edge_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mdio_oe && $past(mdio_oe) && (mdio_o != $past(mdio_o))) |-> $past(mdc_rise));

    // the first driven bit of a read is the turnaround zero
    assert_turn_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mdio_oe) |-> !mdio_o);

    // a bus write commits only on the edge of the last data bit
    assert_commit_on_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> $past(mdc_rise));

    // a write frame never turns the driver on
    assert_write_no_drive_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> !mdio_oe);
endmodule

bind phy_mgmt_target phy_mgmt_target_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mdc_rise (mdc_rise),
    .mdio_o   (mdio_o),
    .mdio_oe  (mdio_oe_o),
    .bus_we   (bus_we)
);

// File: tb/phy_mgmt_target_tb_top.sv
module phy_mgmt_target_tb_top;
    localparam int HALF = 8;
    localparam logic [4:0] MY_ADDR = 5'h0B;
    localparam int NV = 11;
    // entry: {is_read, station, register, write data}
    localparam logic [26:0] VECS [NV] = '{
        {1'b0, 5'h0B, 5'h03, 16'hA5C3},
        {1'b0, 5'h0B, 5'h1F, 16'h8001},
        {1'b0, 5'h0B, 5'h00, 16'hFFFF},
        {1'b0, 5'h04, 5'h03, 16'h1234},
        {1'b1, 5'h0B, 5'h03, 16'h0000},
        {1'b1, 5'h0B, 5'h1F, 16'h0000},
        {1'b1, 5'h0B, 5'h00, 16'h0000},
        {1'b1, 5'h04, 5'h03, 16'h0000},
        {1'b0, 5'h0B, 5'h03, 16'h0000},
        {1'b1, 5'h0B, 5'h03, 16'h0000},
        {1'b1, 5'h0B, 5'h10, 16'h0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdc = 1'b0;
    logic        m_en = 1'b0;
    logic        m_val = 1'b1;
    logic        mdio_line;
    logic        dut_o;
    logic        dut_oe;
    logic        loc_we = 1'b0;
    logic [4:0]  loc_waddr = '0;
    logic [15:0] loc_wdata = '0;
    logic [4:0]  loc_raddr = '0;
    logic [15:0] loc_rdata;

    int n_run = 0;
    int n_fail = 0;
    int oe_cycles = 0;
    logic [15:0] shadow [32];

    always #10 clk = ~clk;

    assign mdio_line = dut_oe ? dut_o : (m_en ? m_val : 1'b1);

    always @(posedge clk) if (dut_oe) oe_cycles <= oe_cycles + 1;

    phy_mgmt_target dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .mdc_i       (mdc),
        .mdio_i      (mdio_line),
        .mdio_o      (dut_o),
        .mdio_oe_o   (dut_oe),
        .phy_addr_i  (MY_ADDR),
        .loc_we_i    (loc_we),
        .loc_waddr_i (loc_waddr),
        .loc_wdata_i (loc_wdata),
        .loc_raddr_i (loc_raddr),
        .loc_rdata_o (loc_rdata)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic mbit(input logic en, input logic v, output logic s);
        m_en  = en;
        m_val = v;
        repeat (HALF) @(negedge clk);
        s   = mdio_line;
        mdc = 1'b1;
        repeat (HALF) @(negedge clk);
        mdc = 1'b0;
    endtask

    task automatic frame(input int npre, input logic [1:0] st, input logic [1:0] op,
                         input logic [4:0] phy, input logic [4:0] rg,
                         input logic [15:0] wd, input logic rd_mode,
                         output logic [17:0] got);
        logic s;
        logic [13:0] hdr;
        hdr = {st, op, phy, rg};
        for (int i = 0; i < npre; i++) mbit(1'b1, 1'b1, s);
        for (int i = 13; i >= 0; i--) mbit(1'b1, hdr[i], s);
        for (int i = 0; i < 18; i++) begin
            if (rd_mode) mbit(1'b0, 1'b0, s);
            else if (i < 2) mbit(1'b1, (i == 0), s);
            else mbit(1'b1, wd[17-i], s);
            got[17-i] = s;
        end
        m_en = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic loc_read(input logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        loc_raddr = a;
        #1;
        v = loc_rdata;
    endtask

    task automatic loc_write(input logic [4:0] a, input logic [15:0] v);
        @(negedge clk);
        loc_we = 1'b1; loc_waddr = a; loc_wdata = v;
        @(negedge clk);
        loc_we = 1'b0;
    endtask

    task automatic bus_read(input string req, input logic [4:0] phy,
                            input logic [4:0] rg, input logic [15:0] expd);
        logic [17:0] got;
        int c0;
        logic hit;
        hit = (phy == MY_ADDR);
        c0 = oe_cycles;
        frame(32, 2'b01, 2'b10, phy, rg, 16'h0, 1'b1, got);
        check(req, "read bits", {14'h0, got}, hit ? {14'h0, 2'b10, expd} : 32'h3FFFF);
        check(req, "driver used", (oe_cycles > c0), hit);
        check("R6", "released after read", dut_oe, 1'b0);
    endtask

    initial begin
        logic [17:0] got;
        logic [15:0] v;
        logic [26:0] e;
        int c0;
        int bad;
        for (int i = 0; i < 32; i++) shadow[i] = 16'h0;

        // R1: reset state
        repeat (5) @(negedge clk);
        check("R1", "oe in reset", dut_oe, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check("R1", "oe after reset", dut_oe, 1'b0);
        bad = 0;
        for (int i = 0; i < 32; i++) begin
            loc_read(5'(i), v);
            if (v !== 16'h0) bad++;
        end
        check("R1", "registers nonzero", bad, 0);

        // table walk: R5 R6 R7
        for (int k = 0; k < NV; k++) begin
            e = VECS[k];
            if (e[26]) begin
                bus_read(e[20:16] == MY_ADDR ? "R6" : "R5", e[25:21], e[20:16],
                         shadow[e[20:16]]);
            end else begin
                c0 = oe_cycles;
                frame(32, 2'b01, 2'b01, e[25:21], e[20:16], e[15:0], 1'b0, got);
                if (e[25:21] == MY_ADDR) shadow[e[20:16]] = e[15:0];
                check("R7", "write frame drove line", (oe_cycles > c0), 1'b0);
            end
        end
        loc_read(5'h1F, v);
        check("R7", "bus write seen locally", v, shadow[31]);
        loc_read(5'h03, v);
        check("R5", "foreign write left reg3", v, shadow[3]);

        // R10: local write then bus read
        loc_write(5'h07, 16'h5A5A);
        shadow[7] = 16'h5A5A;
        loc_read(5'h07, v);
        check("R10", "local readback", v, 16'h5A5A);
        bus_read("R10", MY_ADDR, 5'h07, 16'h5A5A);

        // R2: 31 ones is too short
        frame(31, 2'b01, 2'b01, MY_ADDR, 5'h02, 16'h1111, 1'b0, got);
        loc_read(5'h02, v);
        check("R2", "short preamble write", v, 16'h0000);
        // R2: longer preamble accepted
        frame(40, 2'b01, 2'b01, MY_ADDR, 5'h02, 16'h2222, 1'b0, got);
        loc_read(5'h02, v);
        check("R2", "long preamble write", v, 16'h2222);

        // R8: back-to-back frame without preamble
        frame(0, 2'b01, 2'b01, MY_ADDR, 5'h02, 16'h3333, 1'b0, got);
        loc_read(5'h02, v);
        check("R8", "no fresh preamble", v, 16'h2222);

        // R3: bad start pattern
        frame(32, 2'b00, 2'b01, MY_ADDR, 5'h09, 16'h4440, 1'b0, got);
        loc_read(5'h09, v);
        check("R3", "bad start write", v, 16'h0000);

        // R4: unsupported access codes
        frame(32, 2'b01, 2'b11, MY_ADDR, 5'h09, 16'h5550, 1'b0, got);
        loc_read(5'h09, v);
        check("R4", "code 11 write", v, 16'h0000);
        c0 = oe_cycles;
        frame(32, 2'b01, 2'b00, MY_ADDR, 5'h07, 16'h0, 1'b1, got);
        check("R4", "code 00 drove line", (oe_cycles > c0), 1'b0);
        check("R4", "code 00 bits", {14'h0, got}, 32'h3FFFF);

        // R8: after an ignored frame a fresh preamble restores service
        bus_read("R8", MY_ADDR, 5'h07, 16'h5A5A);
        bus_read("R6", MY_ADDR, 5'h02, 16'h2222);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run + 1, n_fail + 1);
        $finish;
    end
endmodule